// File: doc/BRIEF.md
# Masked-Write Multichannel SAR ADC Sequencer

This block is the register front end and conversion sequencer for a successive-approximation ADC with up to eight input channels and 12-bit results. Software writes a 32-bit word to a control register in which the upper half-word is a per-bit write mask. A bit in the lower half changes only when its mask bit is set. Setting the start and single-shot bits launches one conversion on the channel held in the low nibble.

Each conversion has three phases. First a programmable settle time, then a programmable sampling window with the input selector held steady, then twelve trial cycles that resolve the code from the most significant bit down. The trial code goes to the analog side and a single comparator bit comes back. The finished code lands in that channel's own result register. A completion flag is raised and drives the interrupt line when enabled. Software clears the flag by writing a one to it. The start bit drops by itself when the conversion ends.

Top module: `masked_adc_ctrl`

## Requirements
- R1: After reset the control word, interrupt enable, completion flag, busy flag and all result registers read 0. The settle-time register (offset 0x004) reads 0x20 and the sample-time register (offset 0x00C) reads 0x0C.
- R2: A write to the control register (offset 0x000: channel bits [3:0], start bit 4, single bit 5) or to the interrupt enable (offset 0x104, bit 0) changes lower bit i only when bit i+16 of the written word is 1.
- R3: A conversion begins only when start and single are both 1. With start set and single clear, busy stays 0 and the control word keeps its value.
- R4: Busy (offset 0x10C, bit 0) stays high for exactly max(settle,1) + max(sample,1) + 12 clock cycles after the clock edge that follows the launching write.
- R5: The result is resolved MSB first by comparing trial codes against the input. It is stored in the result register at offset 0x120 + 4*channel, and the other result registers keep their values.
- R6: When a conversion completes, the start bit clears, while the channel and single bits keep their values.
- R7: Completion sets bit 0 of the flag register at offset 0x110. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: The interrupt output is high exactly when the interrupt enable and the completion flag are both 1.
- R9: Reads of offsets that no register occupies return 0. Writes to such offsets change no register.
- R10: A launch with channel 8 to 15 runs the full sequence and raises the completion flag, but changes no result register.
- R11: The settle and sample registers take the low 8 bits of a write directly, with no mask. The sampling output is high for exactly max(sample,1) cycles of each conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset for reads and writes |
| wdata | input | 32 | Write data; upper half is the mask for masked registers |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Completion interrupt |
| ain_sel | output | 4 | Channel selector to the analog multiplexer |
| samp | output | 1 | High during the sampling window |
| dac_code | output | 12 | Trial code to the comparator DAC |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |

## Verification
A sequencer stuck in the wrong phase shows up at once on the busy bit and on the sampling output, because their high-time deviates from the cycle count the two timing registers predict. A wrong bit decision during resolution leaves a code that differs from the comparator model's input value, visible in the result register as soon as busy falls. A wrongly latched channel index writes into a neighbour's register, so every result register is read back after every conversion. A mask decoded at the wrong offset shows up after a single write and read-back of the control word.

// File: rtl/masked_adc_ctrl.sv
module masked_adc_ctrl #(
  parameter int NCH    = 8,
  parameter int RES    = 12,
  parameter int TW     = 8,
  parameter int AW     = 12,
  parameter int TP_RST = 'h20,
  parameter int TS_RST = 'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq,
  output logic [3:0]    ain_sel,
  output logic          samp,
  output logic [RES-1:0] dac_code,
  input  logic          cmp_in
);
  localparam int BW = $clog2(RES);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_CTRL = AW'('h000);
  localparam logic [AW-1:0] A_TP   = AW'('h004);
  localparam logic [AW-1:0] A_TS   = AW'('h00C);
  localparam logic [AW-1:0] A_IEN  = AW'('h104);
  localparam logic [AW-1:0] A_STAT = AW'('h10C);
  localparam logic [AW-1:0] A_IST  = AW'('h110);
  localparam int           A_DATA = 'h120;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SAMP, S_CONV} st_t;

  st_t            st;
  logic [3:0]     ctrl_ch, cur_ch;
  logic           ctrl_start, ctrl_single;
  logic [TW-1:0]  t_pd, t_smp, cnt;
  logic           int_en, int_st;
  logic [BW-1:0]  bidx;
  logic [RES-1:0] sar, trial;
  logic [RES-1:0] res_q [NCH];
  logic           busy, done, launch;

  wire [15:0] wmask = wdata[31:16];
  wire [5:0]  ctrl_new = ({ctrl_single, ctrl_start, ctrl_ch} & ~wmask[5:0]) |
                         (wdata[5:0] & wmask[5:0]);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[15:TW], wmask[15:6]};

  function automatic logic at_end(input logic [TW-1:0] c, input logic [TW-1:0] t);
    return ((TW+1)'(c) + (TW+1)'(1)) >= (TW+1)'(t);
  endfunction

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_CONV) && (bidx == '0);
  assign launch   = (st == S_IDLE) && ctrl_start && ctrl_single;
  assign trial    = sar | (RES'(1) << bidx);
  assign dac_code = (st == S_CONV) ? trial : '0;
  assign samp     = (st == S_SAMP);
  assign ain_sel  = cur_ch;
  assign irq      = int_en & int_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctrl_single, ctrl_start, ctrl_ch} <= '0;
      t_pd   <= TW'(TP_RST);
      t_smp  <= TW'(TS_RST);
      int_en <= 1'b0;
      int_st <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) {ctrl_single, ctrl_start, ctrl_ch} <= ctrl_new;
      if (done) ctrl_start <= 1'b0;
      if (wr_en && addr == A_TP) t_pd <= wdata[TW-1:0];
      if (wr_en && addr == A_TS) t_smp <= wdata[TW-1:0];
      if (wr_en && addr == A_IEN && wmask[0]) int_en <= wdata[0];
      if (done) int_st <= 1'b1;
      else if (wr_en && addr == A_IST && wdata[0]) int_st <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sar    <= '0;
      cur_ch <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          st     <= S_WAIT;
          cnt    <= '0;
          sar    <= '0;
          cur_ch <= ctrl_ch;
        end
        S_WAIT: if (at_end(cnt, t_pd)) begin
          st  <= S_SAMP;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_SAMP: if (at_end(cnt, t_smp)) begin
          st   <= S_CONV;
          bidx <= BW'(RES - 1);
        end else cnt <= cnt + 1'b1;
        default: begin
          if (cmp_in) sar <= trial;
          if (bidx == '0) st <= S_IDLE;
          else bidx <= bidx - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) res_q[k] <= '0;
    end else if (done && 32'(cur_ch) < NCH) begin
      res_q[cur_ch[IW-1:0]] <= cmp_in ? trial : sar;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = 32'({ctrl_single, ctrl_start, ctrl_ch});
      A_TP:   rdata = 32'(t_pd);
      A_TS:   rdata = 32'(t_smp);
      A_IEN:  rdata = 32'(int_en);
      A_STAT: rdata = 32'(busy);
      A_IST:  rdata = 32'(int_st);
      default: begin
        for (int k = 0; k < NCH; k++)
          if (addr == AW'(A_DATA + 4*k)) rdata = 32'(res_q[k]);
      end
    endcase
  end
endmodule

module adc_ctrl_checker #(
  parameter int AW  = 12,
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           samp,
  input logic           ctrl_start,
  input logic           ctrl_single,
  input logic [3:0]     ctrl_ch,
  input logic           int_st,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [31:0]    wdata,
  input logic [RES-1:0] dac_code
);
  assert_launch_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_start && ctrl_single));
  assert_start_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ctrl_start);
  assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> int_st);
  assert_samp_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> busy);
  assert_mask_holds_ch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wdata[19:16] == 4'h0) |=> $stable(ctrl_ch));
  assert_no_trial_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_code == '0);
endmodule

bind masked_adc_ctrl adc_ctrl_checker #(.AW(AW), .RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .samp(samp),
  .ctrl_start(ctrl_start), .ctrl_single(ctrl_single), .ctrl_ch(ctrl_ch),
  .int_st(int_st), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .dac_code(dac_code)
);

// File: tb/masked_adc_ctrl_bench.sv
module masked_adc_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmp_in;
  logic [11:0] addr = '0, dac_code;
  logic [31:0] wdata = '0, rdata;
  logic        irq, samp;
  logic [3:0]  ain_sel;
  logic [11:0] ain [8];
  logic [11:0] exp_d [8];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  masked_adc_ctrl u_masked_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .ain_sel(ain_sel), .samp(samp),
    .dac_code(dac_code), .cmp_in(cmp_in)
  );

  assign cmp_in = (ain[ain_sel[2:0]] >= dac_code);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic run_conv(input int ch, output int bcyc, output int scyc);
    wr(12'h000, 32'h003F_0030 | 32'(ch));
    addr = 12'h10C; bcyc = 0; scyc = 0;
    @(negedge clk); #1;
    while (rdata[0] && bcyc < 10000) begin
      bcyc++;
      if (samp) scyc++;
      @(negedge clk); #1;
    end
  endtask

  task automatic check_data(input string req);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(12'(32'h120 + 4*k), v);
      chk(req, v, 32'(exp_d[k]));
    end
  endtask

  function automatic int mx1(input int t);
    return (t < 1) ? 1 : t;
  endfunction

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    int bc, sc;
    int tps [4] = '{0, 1, 3, 32};
    int tss [3] = '{0, 2, 12};
    logic [11:0] codes [6] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'h555, 12'hAAA};
    for (int k = 0; k < 8; k++) begin ain[k] = '0; exp_d[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd(12'h000, v); chk("R1 ctrl", v, 0);
    rd(12'h004, v); chk("R1 settle", v, 32'h20);
    rd(12'h00C, v); chk("R1 sample", v, 32'h0C);
    rd(12'h104, v); chk("R1 ien", v, 0);
    rd(12'h10C, v); chk("R1 busy", v, 0);
    rd(12'h110, v); chk("R1 flag", v, 0);
    chk("R1 irq", 32'(irq), 0);
    check_data("R1 data");

    // R9 unmapped reads
    rd(12'h008, v); chk("R9 rd 008", v, 0);
    rd(12'h100, v); chk("R9 rd 100", v, 0);
    rd(12'h122, v); chk("R9 rd 122", v, 0);
    rd(12'h140, v); chk("R9 rd 140", v, 0);
    rd(12'hFFC, v); chk("R9 rd FFC", v, 0);

    // R2 masked writes
    wr(12'h000, 32'h0000_0007); rd(12'h000, v); chk("R2 mask0", v, 0);
    wr(12'h000, 32'h0003_000F); rd(12'h000, v); chk("R2 low2", v, 32'h3);
    wr(12'h000, 32'h0008_000C); rd(12'h000, v); chk("R2 bit3", v, 32'hB);
    wr(12'h104, 32'h0000_0001); rd(12'h104, v); chk("R2 ien mask0", v, 0);
    wr(12'h104, 32'h0001_0001); rd(12'h104, v); chk("R2 ien set", v, 1);
    wr(12'h104, 32'h0001_0000); rd(12'h104, v); chk("R2 ien clr", v, 0);

    // R3 start without single
    wr(12'h000, 32'h0010_0010);
    repeat (80) @(negedge clk);
    rd(12'h10C, v); chk("R3 no launch busy", v, 0);
    rd(12'h000, v); chk("R3 ctrl kept", v, 32'h1B);
    rd(12'h110, v); chk("R3 no flag", v, 0);
    wr(12'h000, 32'h003F_0000);

    // R11 plain timing writes
    wr(12'h004, 32'h0000_FF05); rd(12'h004, v); chk("R11 settle wr", v, 32'h05);
    wr(12'h00C, 32'h0000_0003); rd(12'h00C, v); chk("R11 sample wr", v, 32'h03);

    // R4 / R11 timing sweep
    foreach (tps[i]) foreach (tss[j]) begin
      wr(12'h004, 32'(tps[i]));
      wr(12'h00C, 32'(tss[j]));
      ain[0] = 12'(37 * (i + 1) + j);
      exp_d[0] = ain[0];
      run_conv(0, bc, sc);
      chk("R4 busy cycles", 32'(bc), 32'(mx1(tps[i]) + mx1(tss[j]) + 12));
      chk("R11 samp cycles", 32'(sc), 32'(mx1(tss[j])));
      rd(12'h120, v); chk("R5 ch0 code", v, 32'(exp_d[0]));
    end

    // R5 / R6 channel and code sweep
    wr(12'h004, 32'h1);
    wr(12'h00C, 32'h1);
    for (int ch = 0; ch < 8; ch++) begin
      for (int c = 0; c < 7; c++) begin
        ain[ch] = (c < 6) ? codes[c] : 12'(ch * 32'h1F3 + 7);
        exp_d[ch] = ain[ch];
        run_conv(ch, bc, sc);
        rd(12'h000, v); chk("R6 start cleared", v, 32'h20 | 32'(ch));
        check_data("R5 result bank");
      end
    end

    // R7 / R8 completion flag and interrupt
    wr(12'h110, 32'h1); rd(12'h110, v); chk("R7 clear", v, 0);
    chk("R8 irq low", 32'(irq), 0);
    wr(12'h104, 32'h0001_0001);
    ain[4] = 12'h3C3; exp_d[4] = 12'h3C3;
    run_conv(4, bc, sc);
    rd(12'h110, v); chk("R7 set", v, 1);
    chk("R8 irq high", 32'(irq), 1);
    wr(12'h110, 32'h0); rd(12'h110, v); chk("R7 write0 keeps", v, 1);
    wr(12'h104, 32'h0001_0000); #1; chk("R8 irq masked", 32'(irq), 0);
    wr(12'h104, 32'h0001_0001); #1; chk("R8 irq back", 32'(irq), 1);
    wr(12'h110, 32'h1); #1; chk("R8 irq cleared", 32'(irq), 0);
    rd(12'h110, v); chk("R7 w1c", v, 0);

    // R10 out-of-range channel
    run_conv(9, bc, sc);
    chk("R10 busy cycles", 32'(bc), 32'(1 + 1 + 12));
    rd(12'h110, v); chk("R10 flag", v, 1);
    check_data("R10 bank unchanged");

    // R9 unmapped writes
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h140, 32'hFFFF_FFFF);
    wr(12'h10C, 32'hFFFF_FFFF);
    wr(12'h122, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R9 ctrl kept", v, 32'h29);
    rd(12'h004, v); chk("R9 settle kept", v, 1);
    rd(12'h00C, v); chk("R9 sample kept", v, 1);
    rd(12'h104, v); chk("R9 ien kept", v, 1);
    rd(12'h110, v); chk("R9 flag kept", v, 1);
    rd(12'h10C, v); chk("R9 idle", v, 0);
    check_data("R9 bank kept");

    summary();
  end
endmodule